// File: doc/BRIEF.md
# Trigger packet header stripper

This block sits between a network receiver and an event-indexed data buffer. Trigger-decision packets arrive as a stream of 32-bit words. A start-of-packet flag marks the first word of a packet and an end-of-packet flag marks the last. The block drops the ten protocol header words at the front of every packet. It keeps the eight trigger payload words that follow and passes them through a six-entry FIFO to a synchronous buffer write port.

Each payload word is written at an address built from two parts. The high bits are a slot number taken from the event identifier in the first payload word. The low three bits are the word's position within the payload. As a result every event lands in its own eight-word slot.

The receive side uses a valid/ready handshake. A word transfers on a clock edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, the source holds the word, its flags and `in_valid` steady. `in_ready` depends only on how full the FIFO is, never on `in_valid`.

The buffer side is a plain write port qualified by a grant, `buf_ready`. A write happens in any cycle where the FIFO holds an entry and the grant is high. Writes are never issued without the grant.

A packet that ends before its 18th word is a length error. A packet cut short by a fresh start-of-packet is also a length error. In both cases `len_err` pulses, and the packet's payload words still waiting in the FIFO are thrown away. A completely committed packet raises `pkt_done` together with the write of its last payload word, so a processed-packet counter can count it.

Top module: `trig_hdr_strip`

## Requirements
- R1: After reset, `in_ready` is 1 and `buf_we`, `pkt_done` and `len_err` are 0.
- R2: The first ten accepted words of a packet, counting the start-of-packet word as word 0, never produce a buffer write.
- R3: Accepted words 10 to 17 of a packet are written to the buffer in arrival order. `buf_wdata` equals the word, and `buf_addr` = {slot, index}. The slot is bits [7:0] of word 10 and the index runs 0 to 7.
- R4: `buf_we` is high only in cycles where `buf_ready` is high, with at most one FIFO entry written per cycle. Up to six payload words are held while the grant is low.
- R5: `in_ready` is low exactly while six payload words are held. Every word accepted as payload is written once and none is lost.
- R6: A length error occurs when end-of-packet comes on word 0 to 16, or when a start-of-packet comes before word 17 was accepted. On a length error, `len_err` is high for one cycle, in the cycle after the word that revealed the error was accepted. That terminating word is not written. Payload words of the cut packet that are still in the FIFO are discarded and produce no write, and the cut packet produces no `pkt_done`.
- R7: After word 17 of a packet, and after a length error, accepted words are ignored until the next start-of-packet. Words arriving before the first start-of-packet are ignored too.
- R8: `pkt_done` is high for exactly one cycle per complete packet, in the cycle its index-7 word is written (`buf_we` high, `buf_addr[2:0]` = 7).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Receive word valid |
| in_ready | output | 1 | Receive word can be taken |
| in_data | input | 32 | Receive word |
| in_sop | input | 1 | Word is the first of a packet |
| in_eop | input | 1 | Word is the last of a packet |
| buf_ready | input | 1 | Buffer write grant |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | 11 | Buffer write address {slot, index} |
| buf_wdata | output | 32 | Buffer write data |
| pkt_done | output | 1 | Pulse: a complete packet was committed |
| len_err | output | 1 | Pulse: a packet was too short |

## Verification
Two things can land in the same cycle. One is the discard of a cut packet's tail on a length error. The other is the buffer drain writing the FIFO head, which may belong to an earlier complete packet or to the cut packet itself. The bench provokes this by toggling the write grant at random while short, cut and complete packets are interleaved. It judges the result with a scoreboard: every complete packet must be written in full and in order, and a cut packet may leave at most a leading run of its payload in the buffer, with no `pkt_done` for it.

// File: rtl/trig_strip_pkg.sv
package trig_strip_pkg;
  parameter int DATA_W    = 32;
  parameter int SLOT_W    = 8;
  parameter int PAY_WORDS = 8;
  localparam int IDX_W    = $clog2(PAY_WORDS);
  localparam int ADDR_W   = SLOT_W + IDX_W;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PAY} rx_state_e;

  typedef struct packed {
    logic              last;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } pay_entry_t;
endpackage

// File: rtl/trig_strip_rx.sv
module trig_strip_rx
  import trig_strip_pkg::*;
#(
  parameter int HDR_WORDS  = 10,
  parameter int FIFO_DEPTH = 6,
  localparam int HC_W  = $clog2(HDR_WORDS + 1),
  localparam int PC_W  = $clog2(PAY_WORDS + 1),
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [CNT_W-1:0] fifo_level,
  input  logic             fifo_pop,
  output logic             push,
  output logic             first_word,
  output logic             last_word,
  output logic [IDX_W-1:0] word_idx,
  output logic [CNT_W-1:0] rewind_n,
  output logic             len_err
);
  rx_state_e       state_q, state_d;
  logic [HC_W-1:0] hcnt_q, hcnt_d;
  logic [PC_W-1:0] pidx_q, pidx_d;
  logic            err_now;

  always_comb begin
    state_d = state_q;
    hcnt_d  = hcnt_q;
    pidx_d  = pidx_q;
    err_now = 1'b0;
    push    = 1'b0;
    if (acc) begin
      if (in_sop) begin
        // a packet still in progress is cut short by a new start
        err_now = (state_q != ST_IDLE) || in_eop;
        state_d = in_eop ? ST_IDLE : ST_HDR;
        hcnt_d  = HC_W'(1);
        pidx_d  = '0;
      end else begin
        unique case (state_q)
          ST_HDR: begin
            if (in_eop) begin
              err_now = 1'b1;
              state_d = ST_IDLE;
            end else if (hcnt_q == HC_W'(HDR_WORDS - 1)) begin
              state_d = ST_PAY;
              pidx_d  = '0;
            end else begin
              hcnt_d = hcnt_q + HC_W'(1);
            end
          end
          ST_PAY: begin
            if (in_eop && (pidx_q != PC_W'(PAY_WORDS - 1))) begin
              err_now = 1'b1;
              state_d = ST_IDLE;
            end else begin
              push   = 1'b1;
              pidx_d = pidx_q + PC_W'(1);
              if (pidx_q == PC_W'(PAY_WORDS - 1)) state_d = ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // Entries of the cut packet sit at the FIFO tail; count those still present.
  always_comb begin
    int left;
    int mine;
    left = int'(fifo_level) - int'(fifo_pop);
    mine = int'(pidx_q);
    rewind_n = '0;
    if (err_now && (state_q == ST_PAY))
      rewind_n = CNT_W'((mine < left) ? mine : left);
  end

  assign word_idx   = pidx_q[IDX_W-1:0];
  assign first_word = push && (pidx_q == '0);
  assign last_word  = (pidx_q == PC_W'(PAY_WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hcnt_q  <= '0;
      pidx_q  <= '0;
      len_err <= 1'b0;
    end else begin
      state_q <= state_d;
      hcnt_q  <= hcnt_d;
      pidx_q  <= pidx_d;
      len_err <= err_now;
    end
  end

  // R7
  pidx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pidx_q <= PC_W'(PAY_WORDS));

  // R6
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> !$past(push));
endmodule

// File: rtl/trig_strip_addr.sv
module trig_strip_addr
  import trig_strip_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              first_word,
  input  logic [SLOT_W-1:0] evid_field,
  input  logic [IDX_W-1:0]  word_idx,
  output logic [ADDR_W-1:0] addr
);
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          slot_q <= '0;
    else if (first_word) slot_q <= evid_field;
  end

  assign addr = {(first_word ? evid_field : slot_q), word_idx};
endmodule

// File: rtl/trig_strip_fifo.sv
module trig_strip_fifo
  import trig_strip_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  pay_entry_t       wr_entry,
  input  logic             pop,
  input  logic [CNT_W-1:0] rewind_n,
  output pay_entry_t       rd_entry,
  output logic [CNT_W-1:0] level,
  output logic             full,
  output logic             empty
);
  pay_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    if (s >= DEPTH) s = s - DEPTH;
    if (s < 0)      s = s + DEPTH;
    return PTR_W'(s);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= push ? ptr_step(wr_q, 1) : ptr_step(wr_q, -int'(rewind_n));
      rd_q  <= pop ? ptr_step(rd_q, 1) : rd_q;
      cnt_q <= CNT_W'(int'(cnt_q) + int'(push) - int'(pop) - int'(rewind_n));
    end
  end

  assign rd_entry = mem[rd_q];
  assign level    = cnt_q;
  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign empty    = (cnt_q == '0);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R5
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R6
  rewind_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rewind_n) + int'(pop)) <= int'(cnt_q));
endmodule

// File: rtl/trig_hdr_strip.sv
module trig_hdr_strip
  import trig_strip_pkg::*;
#(
  parameter int HDR_WORDS  = 10,
  parameter int FIFO_DEPTH = 6,
  parameter int EVID_LSB   = 0,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              buf_ready,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [DATA_W-1:0] buf_wdata,
  output logic              pkt_done,
  output logic              len_err
);
  logic             acc, push, first_word, last_word, pop, full, empty;
  logic [IDX_W-1:0] word_idx;
  logic [CNT_W-1:0] level, rewind_n;
  logic [ADDR_W-1:0] wr_addr;
  pay_entry_t       wr_entry, rd_entry;

  assign in_ready = !full;
  assign acc      = in_valid && in_ready;
  assign pop      = !empty && buf_ready;

  trig_strip_rx #(.HDR_WORDS(HDR_WORDS), .FIFO_DEPTH(FIFO_DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .acc(acc), .in_sop(in_sop), .in_eop(in_eop),
    .fifo_level(level), .fifo_pop(pop), .push(push), .first_word(first_word),
    .last_word(last_word), .word_idx(word_idx), .rewind_n(rewind_n),
    .len_err(len_err)
  );

  trig_strip_addr u_addr (
    .clk(clk), .rst_n(rst_n), .first_word(first_word),
    .evid_field(in_data[EVID_LSB +: SLOT_W]), .word_idx(word_idx),
    .addr(wr_addr)
  );

  assign wr_entry = '{last: last_word, addr: wr_addr, data: in_data};

  trig_strip_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .wr_entry(wr_entry), .pop(pop),
    .rewind_n(rewind_n), .rd_entry(rd_entry), .level(level), .full(full),
    .empty(empty)
  );

  assign buf_we    = pop;
  assign buf_addr  = rd_entry.addr;
  assign buf_wdata = rd_entry.data;
  assign pkt_done  = pop && rd_entry.last;

  // R8
  done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> (buf_we && (buf_addr[IDX_W-1:0] == IDX_W'(PAY_WORDS - 1))));

  // R4
  grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> buf_ready);
endmodule

// File: tb/trig_hdr_strip_tb.sv
module trig_hdr_strip_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [31:0] in_data = '0;
  logic        buf_ready = 1'b1;
  logic        in_ready, buf_we, pkt_done, len_err;
  logic [10:0] buf_addr;
  logic [31:0] buf_wdata;

  always #10 clk = ~clk;

  trig_hdr_strip u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .buf_ready(buf_ready),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .pkt_done(pkt_done), .len_err(len_err)
  );

  typedef struct {
    logic [10:0] addr;
    logic [31:0] data;
    bit          opt;
    int          grp;
    bit          last;
  } exp_t;

  exp_t sbq[$];
  int n_run = 0, n_fail = 0;
  int acc_words = 0, wr_cnt = 0, err_cnt = 0, done_cnt = 0;
  int exp_err = 0, exp_done = 0, grp_id = 0;
  int br_mode = 1;
  bit drv_busy = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // write-grant driver: 0 low, 1 high, 2 random
  initial begin
    forever begin
      @(posedge clk);
      #1;
      buf_ready = (br_mode == 2) ? 1'($urandom % 2) : (br_mode != 0);
    end
  end

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (len_err) err_cnt++;
      if (pkt_done) done_cnt++;
      if (pkt_done && !buf_we) chk(1'b0, "R8 pkt_done without write", 0, 1);
      if (buf_we && !buf_ready) chk(1'b0, "R4 write without grant", 1, 0);
      if (buf_we) begin
        bit matched;
        wr_cnt++;
        matched = 1'b0;
        while (!matched) begin
          if (sbq.size() == 0) begin
            chk(1'b0, "R3 unexpected write addr", longint'(buf_addr), 0);
            matched = 1'b1;
          end else if (sbq[0].addr == buf_addr && sbq[0].data == buf_wdata) begin
            chk(pkt_done == sbq[0].last, "R8 pkt_done on write", pkt_done, sbq[0].last);
            void'(sbq.pop_front());
            matched = 1'b1;
          end else if (sbq[0].opt) begin
            int g;
            g = sbq[0].grp;
            while (sbq.size() > 0 && sbq[0].opt && sbq[0].grp == g) void'(sbq.pop_front());
          end else begin
            chk(1'b0, "R3 write addr/data", {21'd0, buf_addr, buf_wdata},
                {21'd0, sbq[0].addr, sbq[0].data});
            void'(sbq.pop_front());
            matched = 1'b1;
          end
        end
      end
    end
  end

  task automatic put(input logic [31:0] d, input bit s, input bit e);
    bit r;
    in_valid = 1'b1;
    in_data  = d;
    in_sop   = s;
    in_eop   = e;
    do begin
      @(negedge clk);
      r = in_ready;
      @(posedge clk);
    end while (!r);
    #1;
    in_valid = 1'b0;
    in_sop   = 1'b0;
    in_eop   = 1'b0;
    acc_words++;
  endtask

  task automatic send_pkt(input logic [7:0] slot, input int len, input bit eop_last);
    logic [31:0] words[$];
    bit short_p;
    short_p = (len < 18);
    grp_id++;
    for (int i = 0; i < len; i++) begin
      logic [31:0] w;
      w = $urandom;
      if (i == 10) w[7:0] = slot;
      words.push_back(w);
    end
    for (int k = 10; k < len && k < 18; k++) begin
      exp_t e;
      e.addr = {slot, 3'(k - 10)};
      e.data = words[k];
      e.opt  = short_p;
      e.grp  = grp_id;
      e.last = !short_p && (k == 17);
      sbq.push_back(e);
    end
    if (short_p) exp_err++;
    else         exp_done++;
    for (int i = 0; i < len; i++) put(words[i], i == 0, eop_last && (i == len - 1));
  endtask

  task automatic garbage(input int n);
    for (int i = 0; i < n; i++) put($urandom, 1'b0, 1'b0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int base;
    bit prev_cut;
    void'($urandom(32'h5EED_1234));
    repeat (5) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(buf_we == 1'b0, "R1 buf_we", buf_we, 0);
    chk(pkt_done == 1'b0, "R1 pkt_done", pkt_done, 0);
    chk(len_err == 1'b0, "R1 len_err", len_err, 0);
    @(posedge clk);
    #1;

    // R2 R3 R8 single packet
    send_pkt(8'h3C, 18, 1'b1);
    idle(10);
    chk(wr_cnt == 8, "R3 writes of one packet", wr_cnt, 8);
    chk(done_cnt == 1, "R8 done count", done_cnt, 1);

    // R6 end inside header
    send_pkt(8'h11, 6, 1'b1);
    idle(5);
    chk(err_cnt == 1, "R6 header short err", err_cnt, 1);
    chk(wr_cnt == 8, "R2 header words unwritten", wr_cnt, 8);

    // R6 short payload held back by the grant, then discarded
    br_mode = 0;
    send_pkt(8'h22, 13, 1'b1);
    idle(5);
    chk(wr_cnt == 8, "R6 no write while held", wr_cnt, 8);
    br_mode = 1;
    idle(10);
    chk(wr_cnt == 8, "R6 partial discarded", wr_cnt, 8);
    chk(err_cnt == 2, "R6 payload short err", err_cnt, 2);

    // R4 R5 back-pressure with grant low
    br_mode = 0;
    base = acc_words;
    drv_busy = 1'b1;
    fork
      begin
        send_pkt(8'h5A, 18, 1'b1);
        drv_busy = 1'b0;
      end
    join_none
    idle(40);
    @(negedge clk);
    chk((acc_words - base) == 16, "R5 words taken before stall", acc_words - base, 16);
    chk(in_ready == 1'b0, "R5 in_ready low when six held", in_ready, 0);
    chk(wr_cnt == 8, "R4 no write without grant", wr_cnt, 8);
    @(posedge clk);
    #1;
    br_mode = 1;
    wait (!drv_busy);
    idle(10);
    chk(wr_cnt == 16, "R5 no word lost", wr_cnt, 16);

    // R7 stray words, then over-long packet
    garbage(3);
    send_pkt(8'hA7, 21, 1'b1);
    garbage(2);
    idle(10);
    chk(wr_cnt == 24, "R7 extra words ignored", wr_cnt, 24);
    chk(done_cnt == 3, "R7 done after long packet", done_cnt, 3);

    // R6 cut by new start; partial words already written with grant high
    send_pkt(8'h01, 14, 1'b0);
    send_pkt(8'h02, 18, 1'b1);
    idle(10);
    chk(err_cnt == 3, "R6 cut packet err", err_cnt, 3);
    chk(wr_cnt == 36, "R6 cut packet writes", wr_cnt, 36);
    chk(done_cnt == 4, "R8 no done for cut packet", done_cnt, 4);

    // random mix: grant toggles, short, cut and long packets
    br_mode = 2;
    prev_cut = 1'b0;
    for (int p = 0; p < 250; p++) begin
      int r;
      logic [7:0] slot;
      r = $urandom % 4;
      slot = 8'($urandom);
      if (!prev_cut && ($urandom % 2)) garbage($urandom % 3);
      if (r == 0) begin
        bit cut;
        cut = (p < 249) && ($urandom % 2 == 1);
        send_pkt(slot, 2 + ($urandom % 16), !cut);
        prev_cut = cut;
      end else begin
        send_pkt(slot, 18 + ($urandom % 4), 1'b1);
        prev_cut = 1'b0;
      end
    end
    br_mode = 1;
    idle(40);
    begin
      int req_left;
      req_left = 0;
      foreach (sbq[i]) if (!sbq[i].opt) req_left++;
      chk(req_left == 0, "R3 random missing writes", req_left, 0);
    end
    chk(done_cnt == exp_done, "R8 random done count", done_cnt, exp_done);
    chk(err_cnt == exp_err, "R6 random err count", err_cnt, exp_err);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule